// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns a reference clock of any rate into a 1 MHz tick enable. The reference rate does not have to be a whole number of megahertz. A 16-bit ratio register holds two byte fields. The low byte is the number of reference cycles per group, minus one. The high byte is the number of microseconds in that group, minus one. So the ratio (low+1)/(high+1) is the average number of reference cycles per microsecond.

An accumulator adds the denominator on every reference cycle. When the sum reaches the numerator, the block subtracts the numerator and emits one tick. Because the remainder is kept, the tick rate matches the ratio exactly over any whole group, with no drift. Some example settings:
- 0x000B at 12 MHz (12/1)
- 0x043F at 12.8 MHz (64/5)
- 0x0453 at 16.8 MHz (84/5)
- 0x045F at 19.2 MHz (96/5)
- 0x04BF at 38.4 MHz (192/5)
- 0x002F at 48 MHz (48/1)

Each tick advances a free-running microsecond counter. A hold bit stops both the accumulator and the counter. Software reaches the count, the ratio register and the hold bit through a simple register port. Writes happen in a single cycle. Reads are combinational. There is no data stream here, so every pin is plain control with no valid/ready handshake and no back-pressure.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the count reads 0, the ratio register reads 0x000B, the hold bit reads 0 and tick_o is low.
- R2: The ratio register's bits 7:0 hold the numerator minus one and bits 15:8 hold the denominator minus one. From a cleared accumulator, exactly N*(den) ticks occur in N*(num) cycles, for example 500 ticks in 6400 cycles at 0x043F.
- R3: With a denominator field of 0, ticks are spaced exactly (low+1) cycles apart, for example 10 ticks in 120 cycles at 0x000B.
- R4: tick_o is high for exactly the cycles in which the count has just risen by one, and the count changes at no other time.
- R5: The hold bit is bit 0 at offset 0x4C. Once it is set, starting from the edge after its write, neither the accumulator nor the count advances and tick_o stays low. Clearing it resumes from the kept phase.
- R6: A write of the ratio register at offset 0x14 may happen at any time. It clears the accumulator and produces no tick on its own edge. With a new numerator n, the next tick follows exactly n cycles after the write edge.
- R7: Reads return the count at 0x10, the ratio register zero-extended at 0x14, the hold bit at 0x4C and zero at every other offset. Writes to other offsets change nothing.
- R8: The count wraps to zero after its all-ones value (modulo 2^CNT_W).
- R9: If the denominator field exceeds the numerator field, a tick occurs on every unheld cycle and the accumulator stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | DATA_W | Register read data (combinational) |
| tick_o | output | 1 | One-cycle microsecond tick enable |

## Verification
The bench targets these corner cases:
- Long runs at the fractional ratios. A design that dropped the remainder or compared against the wrong bound would drift by whole ticks over a few hundred microseconds.
- The exact spacing of the first tick after a ratio rewrite. A design that kept the old phase would tick early.
- The hold window. A design that kept accumulating would tick right after release, or would count during the hold.
- An inverted ratio, and an 8-bit counter instance pushed past all-ones, where a wrong wrap or a lost tick would show up at once.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RATIO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HOLD  = 8'h4C;
  localparam logic [15:0] RATIO_RESET = 16'h000B;
endpackage

// File: rtl/usec_cfg_regs.sv
module usec_cfg_regs
  import usec_tick_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [2*FIELD_W-1:0]   ratio_q,
  output logic                   hold_q,
  output logic                   ratio_wr
);
  localparam int unsigned RW = 2*FIELD_W;

  logic hold_wr;

  assign ratio_wr = wr_en && (wr_addr == OFS_RATIO);
  assign hold_wr  = wr_en && (wr_addr == OFS_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= RW'(RATIO_RESET);
      hold_q  <= 1'b0;
    end else begin
      if (ratio_wr) ratio_q <= wr_data[RW-1:0];
      if (hold_wr)  hold_q  <= wr_data[0];
    end
  end
endmodule

// File: rtl/usec_frac_accum.sv
module usec_frac_accum #(
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned ACC_W  = FIELD_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] ratio,
  input  logic                 hold,
  input  logic                 ratio_wr,
  output logic                 step,
  output logic                 tick_q,
  output logic [ACC_W-1:0]     acc_q
);
  logic [ACC_W-1:0] num, den, sum;
  logic             wide, hit;

  assign num  = ACC_W'(ratio[FIELD_W-1:0]) + ACC_W'(1);
  assign den  = ACC_W'(ratio[2*FIELD_W-1:FIELD_W]) + ACC_W'(1);
  assign sum  = acc_q + den;
  assign wide = den > num;
  assign hit  = wide || (sum >= num);
  assign step = !hold && !ratio_wr && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= step;
      if (ratio_wr)     acc_q <= '0;
      else if (!hold) begin
        if (wide)       acc_q <= '0;
        else if (hit)   acc_q <= sum - num;
        else            acc_q <= sum;
      end
    end
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ACC_W  = FIELD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_o
);
  logic [2*FIELD_W-1:0] ratio_q;
  logic                 hold_q;
  logic                 ratio_wr;
  logic                 step;
  logic [ACC_W-1:0]     acc_q;
  logic [CNT_W-1:0]     cnt_q;

  usec_cfg_regs #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ratio_q(ratio_q), .hold_q(hold_q), .ratio_wr(ratio_wr)
  );

  usec_frac_accum #(.FIELD_W(FIELD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .ratio(ratio_q), .hold(hold_q),
    .ratio_wr(ratio_wr), .step(step), .tick_q(tick_o), .acc_q(acc_q)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_q(cnt_q)
  );

  always_comb begin
    case (rd_addr)
      OFS_COUNT: rd_data = DATA_W'(cnt_q);
      OFS_RATIO: rd_data = DATA_W'(ratio_q);
      OFS_HOLD:  rd_data = DATA_W'(hold_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/usec_tick_gen_chk.sv
module usec_tick_gen_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned ACC_W  = FIELD_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [CNT_W-1:0]     cnt,
  input logic [ACC_W-1:0]     acc,
  input logic [2*FIELD_W-1:0] ratio,
  input logic                 hold,
  input logic                 ratio_wr
);
  logic [ACC_W-1:0] c_num, c_den;
  assign c_num = ACC_W'(ratio[FIELD_W-1:0]) + ACC_W'(1);
  assign c_den = ACC_W'(ratio[2*FIELD_W-1:FIELD_W]) + ACC_W'(1);

  assert_tick_bumps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  assert_idle_count_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> $stable(cnt));

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !tick);

  assert_acc_below_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc < c_num);

  assert_rewrite_clears_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> (acc == '0));

  assert_wide_den_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_den > c_num && !hold && !ratio_wr) |=> tick);
endmodule

bind usec_tick_gen usec_tick_gen_chk #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_o), .cnt(cnt_q), .acc(acc_q),
  .ratio(ratio_q), .hold(hold_q), .ratio_wr(ratio_wr)
);

// File: tb/usec_tick_gen_tb_top.sv
module usec_tick_gen_tb_top;
  localparam time PERIOD = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h10;
  logic [31:0] rd_data;
  logic        tick;

  logic        w_wr_en = 1'b0;
  logic [7:0]  w_wr_addr = '0;
  logic [31:0] w_wr_data = '0;
  logic [31:0] w_rd_data;
  logic        w_tick;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  usec_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_o(tick)
  );

  usec_tick_gen #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .wr_en(w_wr_en), .wr_addr(w_wr_addr), .wr_data(w_wr_data),
    .rd_addr(8'h10), .rd_data(w_rd_data), .tick_o(w_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cnt;
  int          m_acc;
  logic [15:0] m_cfg;
  bit          m_frz, m_tick;
  int          m_num, m_den;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_cfg = 16'h000B; m_frz = 0; m_tick = 0;
    end else begin
      m_num = int'(m_cfg[7:0]) + 1;
      m_den = int'(m_cfg[15:8]) + 1;
      if (wr_en && wr_addr == 8'h14) begin
        m_acc = 0; m_tick = 0;
      end else if (m_frz) begin
        m_tick = 0;
      end else begin
        m_acc = m_acc + m_den;
        if (m_den > m_num) begin m_acc = 0; m_tick = 1; end
        else if (m_acc >= m_num) begin m_acc = m_acc - m_num; m_tick = 1; end
        else m_tick = 0;
        if (m_tick) m_cnt = m_cnt + 1;
      end
      if (wr_en && wr_addr == 8'h14) m_cfg = wr_data[15:0];
      if (wr_en && wr_addr == 8'h4C) m_frz = wr_data[0];
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4 tick vs model", {31'b0, tick}, {31'b0, m_tick});
      if (rd_addr == 8'h10) chk("R4 count vs model", rd_data, m_cnt);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_addr = a; #2;
    chk(req, rd_data, exp);
    rd_addr = 8'h10;
  endtask

  task automatic window(input int cyc, input logic [31:0] exp_ticks, input string req);
    logic [31:0] c0;
    #2 c0 = rd_data;
    repeat (cyc) @(negedge clk);
    #2 chk(req, rd_data - c0, exp_ticks);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] c0;
    repeat (5) @(negedge clk);
    // R1: reset values
    #2 chk("R1 count after reset", rd_data, 32'h0);
    chk("R1 tick after reset", {31'b0, tick}, 32'h0);
    rst_n = 1'b1;
    rd_chk(8'h14, 32'h0000_000B, "R1 ratio reset");
    rd_chk(8'h4C, 32'h0, "R1 hold reset");

    // R8: 8-bit counter wraps (ratio 1/1)
    @(negedge clk); w_wr_en = 1'b1; w_wr_addr = 8'h14; w_wr_data = 32'h0;
    @(negedge clk); w_wr_en = 1'b0;
    #2 c0 = w_rd_data;
    repeat (255) @(negedge clk);
    #2 chk("R8 8-bit count before wrap", w_rd_data, (c0 + 255) & 32'hFF);
    @(negedge clk);
    #2 chk("R8 8-bit count wraps", w_rd_data, c0);

    // R3: integer ratio
    wr(8'h14, 32'h0000_000B); window(120, 10, "R3 12/1 tick count");
    wr(8'h14, 32'h0000_002F); window(480, 10, "R3 48/1 tick count");
    // R2: fractional ratios
    wr(8'h14, 32'h0000_043F); window(6400, 500, "R2 64/5 tick count");
    rd_chk(8'h14, 32'h0000_043F, "R2 ratio readback");
    wr(8'h14, 32'h0000_0453); window(8400, 500, "R2 84/5 tick count");
    wr(8'h14, 32'h0000_04BF); window(1920, 50, "R2 192/5 tick count");
    wr(8'h14, 32'h0000_045F); window(960, 50, "R2 96/5 tick count");

    // R6: rewrite mid-run restarts phase
    repeat (7) @(negedge clk);
    wr(8'h14, 32'h0000_0009);
    window(9, 0, "R6 no tick before n cycles");
    window(1, 1, "R6 tick exactly n cycles after rewrite");

    // R5: hold
    wr(8'h4C, 32'h1);
    rd_chk(8'h4C, 32'h1, "R5 hold readback");
    window(50, 0, "R5 count frozen");
    wr(8'h4C, 32'h0);
    window(100, 10, "R5 resumes after release");

    // R7: map and ignored writes
    rd_chk(8'h20, 32'h0, "R7 unmapped read zero");
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h0000_0009, "R7 ratio unchanged by stray write");
    rd_chk(8'h4C, 32'h0, "R7 hold unchanged by stray write");

    // R9: denominator above numerator
    wr(8'h14, 32'h0000_0300);
    window(20, 20, "R9 tick every cycle");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule